// File: doc/BRIEF.md
# Frame Delimiter Hunter and Payload Word Packer

This block sits behind a bit-recovery stage and turns a stream of recovered bits into stored frames. Each accepted bit arrives with a qualifying valid strobe. While idle, the block looks for an eight-bit start marker in the bit stream. After the marker it collects a sixteen-bit length field and checks it against fixed lower and upper bounds. A length outside those bounds sends the block back to marker hunting. A length inside them is written to the first word of a buffer. The block then derives the number of payload bits from that length and packs those bits into 32-bit words, which are written out one by one through a write port.

After the final payload word has been written, the block raises a ready flag and stops taking bits. It holds that state until the host clears the flag with a release pulse, and then returns to hunting for the next marker. Three status outputs report which phase the block is in: marker hunt, frame in progress (from length acceptance until the host releases the frame), and ready.

Top module: `frame_packer`

## Requirements
- R1: After reset, hunt_o is 1, and busy_o, rdy_o and wr_en are 0.
- R2: In the hunt phase, each bit with bit_valid high is shifted into an eight-bit history with the newest bit at the LSB. The hunt ends in the cycle when the history equals 0xA3 (the first received of those eight bits is bit 7). Cycles with bit_valid low leave the history unchanged.
- R3: The 16 valid bits that follow the marker form the length field, first bit received as the MSB.
- R4: A length below 200 or above 32000 returns the block to the hunt with no write, and the marker history is empty afterwards.
- R5: An accepted length is written zero-extended at byte address 0 as a one-cycle wr_en strobe, in the cycle after its last bit is taken.
- R6: The payload holds n = (length - 81) >> 1 bits, and exactly that many valid bits are consumed as payload.
- R7: Payload bits are packed MSB-first: the first bit of each word lands in wr_data[31], and wr_data[31:24] is the byte for the lowest byte address. Payload words go to byte addresses 4, 8, 12 and so on in steps of 4.
- R8: A final partial word is left-justified, with unused low bits 0. When n is a multiple of 32, no extra word is written.
- R9: rdy_o rises in the same cycle as the write of the last payload word. It stays high until a host_clr pulse, after which the block returns to the hunt.
- R10: busy_o is high from length acceptance until the host_clr that ends the frame. hunt_o is high only while hunting.
- R11: While rdy_o is high, incoming bits are ignored. This includes a bit that arrives in the same cycle as host_clr, and the marker history is empty on return to the hunt.
- R12: host_clr has no effect outside the ready wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Recovered data bit |
| host_clr | input | 1 | Host pulse that clears the ready flag |
| wr_en | output | 1 | One-cycle buffer write strobe |
| wr_addr | output | ADDR_W | Byte address of the written word |
| wr_data | output | 32 | Word to store |
| rdy_o | output | 1 | Frame complete, waiting for host |
| hunt_o | output | 1 | Marker hunt in progress |
| busy_o | output | 1 | Frame accepted and not yet released |

## Verification
Two functions can land in the same cycle: the host release of a completed frame and the arrival of a valid bit that the marker hunt could take. The bench drives host_clr and a 1 bit together, then sends the remaining seven bits of 0xA3. If the concurrent bit were taken into the history, those seven bits would complete the marker and end the hunt. The check is that hunt_o stays high. A second coincidence is the last payload bit filling a word exactly: a length giving 64 payload bits must produce one write that both completes the word and raises rdy_o, with no trailing empty word.

// File: rtl/fp_pkg.sv
// Package: shared types for the frame packer.
// Assumes: nothing beyond IEEE 1800-2017.
package fp_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_LEN  = 2'd1,
        ST_PAY  = 2'd2,
        ST_WAIT = 2'd3
    } fp_state_e;

endpackage

// File: rtl/fp_delim_det.sv
// Module: marker detector. It keeps the last W-1 accepted bits and flags
// a match combinationally when the incoming bit completes PATTERN.
// Assumes: shift_en and clear are never needed in the same cycle; clear wins.
module fp_delim_det #(
    parameter int          W       = 8,
    parameter logic [W-1:0] PATTERN = 8'hA3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic clear,
    input  logic bit_in,
    output logic match
);

    logic [W-2:0] hist;
    logic [W-1:0] nxt;

    // Candidate history including the incoming bit.
    always_comb nxt = {hist, bit_in};

    // Match only on a bit actually taken.
    always_comb match = shift_en && (nxt == PATTERN);

    // History register: cleared on reset or request, shifted on accepted bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= nxt[W-2:0];
        end
    end

endmodule

// File: rtl/fp_word_pack.sv
// Module: MSB-first word packer. It gathers bits and emits a word when W
// bits are held or when the flush bit is pushed, left-justified.
// Assumes: flush is meaningful only together with push.
module fp_word_pack #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         flush,
    input  logic         bit_in,
    output logic         word_valid,
    output logic [W-1:0] word_out
);

    localparam int CW = $clog2(W);

    logic [W-2:0]  acc;
    logic [CW-1:0] fill;
    logic [W-1:0]  nacc;
    logic [CW-1:0] shamt;

    // Word including the incoming bit, and the justification shift.
    always_comb begin
        nacc  = {acc, bit_in};
        shamt = CW'(W - 1) - fill;
    end

    // Emit on a full word or on the final bit.
    always_comb begin
        word_valid = push && (flush || (fill == CW'(W - 1)));
        word_out   = nacc << shamt;
    end

    // Accumulator and fill count, restarting after each emitted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            fill <= '0;
        end else if (push) begin
            if (word_valid) begin
                acc  <= '0;
                fill <= '0;
            end else begin
                acc  <= nacc[W-2:0];
                fill <= fill + 1'b1;
            end
        end
    end

    // R8
    // partial_flush_chk: a flush with a part-filled word never sends a set bit below the filled part.
    partial_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && flush && fill == '0) |-> (word_out[W-2:0] == '0));

endmodule

// File: rtl/frame_packer.sv
// Module: frame packer top. It hunts for the start marker, reads and checks
// the length, stores it, packs the payload into words, then waits for the
// host to release the frame.
// Assumes: LEN_MIN > LEN_OFFSET, WORD_W >= LEN_W, and the buffer fits ADDR_W.
module frame_packer
    import fp_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          WORD_W     = 32,
    parameter int          LEN_W      = 16,
    parameter int          DELIM_W    = 8,
    parameter logic [7:0]  DELIM      = 8'hA3,
    parameter int          LEN_MIN    = 200,
    parameter int          LEN_MAX    = 32000,
    parameter int          LEN_OFFSET = 81,
    parameter int          BASE_ADDR  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              host_clr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              rdy_o,
    output logic              hunt_o,
    output logic              busy_o
);

    localparam int              LCW     = $clog2(LEN_W);
    localparam logic [LEN_W-1:0] L_MIN  = LEN_W'(LEN_MIN);
    localparam logic [LEN_W-1:0] L_MAX  = LEN_W'(LEN_MAX);
    localparam logic [LEN_W-1:0] L_OFF  = LEN_W'(LEN_OFFSET);
    localparam int              WBYTES  = WORD_W / 8;

    fp_state_e         state;
    logic [LEN_W-2:0]  len_sh;
    logic [LCW-1:0]    lcnt;
    logic [LEN_W-1:0]  rem;
    logic [ADDR_W-1:0] addr;

    logic [LEN_W-1:0]  new_len;
    logic [LEN_W-1:0]  pay_len;
    logic              len_last;
    logic              len_ok;
    logic              d_match;
    logic              d_clear;
    logic              pk_push;
    logic              pk_valid;
    logic [WORD_W-1:0] pk_word;

    // Length assembly and bound check.
    always_comb begin
        new_len  = {len_sh, bit_in};
        pay_len  = (new_len - L_OFF) >> 1;
        len_last = (state == ST_LEN) && bit_valid && (lcnt == LCW'(LEN_W - 1));
        len_ok   = (new_len >= L_MIN) && (new_len <= L_MAX);
    end

    // Detector clear on host release or on a rejected length.
    always_comb begin
        d_clear = ((state == ST_WAIT) && host_clr) || (len_last && !len_ok);
        pk_push = (state == ST_PAY) && bit_valid;
    end

    fp_delim_det #(.W(DELIM_W), .PATTERN(DELIM)) u_delim (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en ((state == ST_HUNT) && bit_valid),
        .clear    (d_clear),
        .bit_in   (bit_in),
        .match    (d_match)
    );

    fp_word_pack #(.W(WORD_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (pk_push),
        .flush      (rem == LEN_W'(1)),
        .bit_in     (bit_in),
        .word_valid (pk_valid),
        .word_out   (pk_word)
    );

    // Status decode.
    always_comb begin
        hunt_o = (state == ST_HUNT);
        busy_o = (state == ST_PAY) || (state == ST_WAIT);
    end

    // Frame sequencer: hunt, length, payload, host wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_HUNT;
            len_sh  <= '0;
            lcnt    <= '0;
            rem     <= '0;
            addr    <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            rdy_o   <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            case (state)
                ST_HUNT: begin
                    if (d_match) begin
                        state <= ST_LEN;
                        lcnt  <= '0;
                    end
                end
                ST_LEN: begin
                    if (bit_valid) begin
                        len_sh <= new_len[LEN_W-2:0];
                        lcnt   <= lcnt + 1'b1;
                    end
                    if (len_last) begin
                        if (len_ok) begin
                            wr_en   <= 1'b1;
                            wr_addr <= ADDR_W'(BASE_ADDR);
                            wr_data <= WORD_W'(new_len);
                            rem     <= pay_len;
                            addr    <= ADDR_W'(BASE_ADDR + WBYTES);
                            if (pay_len == '0) begin
                                state <= ST_WAIT;
                                rdy_o <= 1'b1;
                            end else begin
                                state <= ST_PAY;
                            end
                        end else begin
                            state <= ST_HUNT;
                        end
                    end
                end
                ST_PAY: begin
                    if (bit_valid) begin
                        rem <= rem - 1'b1;
                        if (pk_valid) begin
                            wr_en   <= 1'b1;
                            wr_addr <= addr;
                            wr_data <= pk_word;
                            addr    <= addr + ADDR_W'(WBYTES);
                        end
                        if (rem == LEN_W'(1)) begin
                            state <= ST_WAIT;
                            rdy_o <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (host_clr) begin
                        state <= ST_HUNT;
                        rdy_o <= 1'b0;
                    end
                end
            endcase
        end
    end

    // R5
    // no_write_in_hunt_chk: no buffer write is ever seen while hunting.
    no_write_in_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !hunt_o);

    // R9
    // ready_with_write_chk: the ready flag comes up together with a stored word.
    ready_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> wr_en);

    // R9
    // ready_hold_chk: without a host release the ready flag stays up.
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && !host_clr) |=> rdy_o);

    // R2
    // hunt_exit_chk: the hunt only ends on an accepted bit.
    hunt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hunt_o) |-> $past(bit_valid));

    // R7
    // word_align_chk: every write address is word aligned.
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr[1:0] == 2'b00));

endmodule

// File: tb/frame_packer_bench.sv
module frame_packer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        host_clr = 1'b0;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic        rdy_o, hunt_o, busy_o;

    int checks = 0;
    int fails  = 0;
    int wcount = 0;
    logic [15:0] cap_addr [0:599];
    logic [31:0] cap_data [0:599];

    // Table: length, payload seed, expected acceptance.
    localparam int NV = 7;
    localparam int unsigned VEC [NV][3] = '{
        '{200,   5, 1},
        '{209,   9, 1},
        '{199,   3, 0},
        '{32001, 4, 0},
        '{257,  77, 1},
        '{32000, 12, 1},
        '{246,   1, 1}
    };

    always #5 clk = ~clk;

    frame_packer u_frame_packer (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .host_clr(host_clr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rdy_o(rdy_o), .hunt_o(hunt_o), .busy_o(busy_o)
    );

    always @(negedge clk) begin
        if (wr_en) begin
            if (wcount < 600) begin
                cap_addr[wcount] = wr_addr;
                cap_data[wcount] = wr_data;
            end
            wcount = wcount + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic bit pbit(input int seed, input int i);
        int v;
        v = seed ^ (i * 13) ^ (i >> 3);
        return 1'((v >> (i % 3)) & 1);
    endfunction

    task automatic send_bit(input bit b, input bit clr = 1'b0);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
        host_clr  = clr;
        @(negedge clk);
        bit_valid = 1'b0;
        host_clr  = 1'b0;
    endtask

    task automatic idle(input int n, input bit clr = 1'b0);
        for (int k = 0; k < n; k++) begin
            host_clr = clr;
            @(negedge clk);
        end
        host_clr = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int k = 7; k >= 0; k--) begin
            send_bit(v[k]);
            if (k == 4) idle(1);
        end
    endtask

    task automatic release_frame();
        @(negedge clk);
        host_clr = 1'b1;
        @(negedge clk);
        host_clr = 1'b0;
    endtask

    // Sends noise, marker, length and payload; checks all writes.
    task automatic run_frame(input int len, input int seed, input bit acc);
        int n, nw;
        logic [31:0] w;
        wcount = 0;
        send_byte(8'h0F);
        send_byte(8'hA3);
        for (int k = 15; k >= 0; k--) send_bit(1'((len >> k) & 1));
        if (!acc) begin
            idle(2);
            chk(wcount == 0, "R4 no write", wcount, 0);
            chk(hunt_o == 1'b1, "R4 back to hunt", hunt_o, 1);
            return;
        end
        n  = (len - 81) >> 1;
        nw = (n + 31) / 32;
        chk(busy_o == 1'b1, "R10 busy after accept", busy_o, 1);
        chk(hunt_o == 1'b0, "R10 hunt low", hunt_o, 0);
        for (int i = 0; i < n; i++) begin
            send_bit(pbit(seed, i));
            if (i % 7 == 6) idle(1, 1'b1); // R12: release during payload
        end
        idle(2);
        chk(wcount == 1 + nw, "R6 R8 write count", wcount, 1 + nw);
        chk(cap_addr[0] == 16'd0, "R5 length address", cap_addr[0], 0);
        chk(cap_data[0] == 32'(len), "R3 R5 length word", cap_data[0], len);
        for (int k = 0; k < nw && k + 1 < wcount; k++) begin
            w = '0;
            for (int j = 0; j < 32; j++)
                if (32 * k + j < n) w[31 - j] = pbit(seed, 32 * k + j);
            chk(cap_addr[k + 1] == 16'(4 + 4 * k), "R7 word address", cap_addr[k + 1], 4 + 4 * k);
            chk(cap_data[k + 1] == w, "R7 R8 word data", cap_data[k + 1], w);
        end
        chk(rdy_o == 1'b1, "R9 ready set", rdy_o, 1);
        chk(busy_o == 1'b1, "R10 busy until release", busy_o, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(hunt_o == 1'b1, "R1 hunt", hunt_o, 1);
        chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
        chk(rdy_o == 1'b0, "R1 ready", rdy_o, 0);
        chk(wr_en == 1'b0, "R1 write", wr_en, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: release pulse while hunting changes nothing.
        release_frame();
        chk(hunt_o == 1'b1 && rdy_o == 1'b0, "R12 release in hunt", hunt_o, 1);

        for (int v = 0; v < NV; v++) begin
            run_frame(int'(VEC[v][0]), int'(VEC[v][1]), VEC[v][2] != 0);
            if (VEC[v][2] != 0) begin
                release_frame();
                chk(rdy_o == 1'b0, "R9 ready cleared", rdy_o, 0);
                chk(hunt_o == 1'b1, "R9 hunt after release", hunt_o, 1);
            end
        end

        // R11: bits during the ready wait are ignored.
        run_frame(200, 21, 1'b1);
        wcount = 0;
        send_byte(8'hA3);
        for (int k = 15; k >= 0; k--) send_bit(1'((210 >> k) & 1));
        idle(2);
        chk(wcount == 0, "R11 no write while waiting", wcount, 0);
        chk(rdy_o == 1'b1, "R11 still waiting", rdy_o, 1);
        // R11: bit coinciding with release is dropped.
        send_bit(1'b1, 1'b1);
        chk(rdy_o == 1'b0, "R11 released", rdy_o, 0);
        send_bit(0); send_bit(1); send_bit(0); send_bit(0);
        send_bit(0); send_bit(1); send_bit(1);
        idle(1);
        chk(hunt_o == 1'b1, "R11 coincident bit ignored", hunt_o, 1);
        // R2: one more bit makes a fresh marker boundary impossible; hunt stays.
        send_bit(0);
        chk(hunt_o == 1'b1, "R2 no false marker", hunt_o, 1);

        // R4: history empty after reject - seven marker bits alone do not match.
        run_frame(150, 2, 1'b0);
        send_bit(0); send_bit(1); send_bit(0); send_bit(0);
        send_bit(0); send_bit(1); send_bit(1);
        idle(1);
        chk(hunt_o == 1'b1, "R4 history cleared", hunt_o, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule